// File: doc/BRIEF.md
# Variable-Delay Echo Mixer

This block takes a stream of unsigned converter samples and returns each one mixed with an echo of an earlier sample. The earlier samples sit in a circular store. A sample index steps once for every accepted input. The store is read at that index. The new sample is written a selectable distance ahead of it, at the index plus the delay selector times 16. The read-back word is treated as signed, halved, and added to the re-centred input. A fixed bias is then added back so that the result suits an unsigned converter.

Samples enter through a valid/ready handshake and leave through a second valid/ready handshake. An upstream source must hold `in_data` and `dly_sel` steady while `in_valid` is high, until a clock edge at which `in_ready` is also high. The block lowers `in_ready` in two cases: while it sweeps the store to zero after reset, and whenever a result waits in its pipeline with nowhere to go. A result stays on `out_data` with `out_valid` high, unchanged, until the consumer raises `out_ready`. Nothing is dropped or reordered. The delay selector is a plain control input, sampled together with each accepted sample.

Top module: `echo_delay_mixer`

## Requirements
- R1: After reset, `out_valid` is low. `in_ready` stays low while the store is swept to zero, which takes one clock per entry (2^ADDR_W cycles, 2048 by default). It rises within one cycle after that sweep.
- R2: Every store entry reads as zero after reset. A result whose echo source was never written therefore carries a zero echo.
- R3: With a nonzero selector S, the echo in the result for sample k comes from sample k − 16·S, counted in accepted samples.
- R4: Stored words are 9-bit two's complement. The echo term is that value divided by two with rounding toward minus infinity (an arithmetic right shift by one), taken as 10 bits.
- R5: Each result equals the input minus 0x181, plus the echo term, plus 0x200, modulo 1024.
- R6: With S = 0, the write and read positions coincide. The read returns the old word, so the echo is the sample from exactly 2^ADDR_W samples earlier.
- R7: The sample index and the write position both wrap modulo 2^ADDR_W, and the ring keeps working across the wrap.
- R8: Only the low 9 bits of an input are stored. Bit 9 of the input affects only the direct path of its own result.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. Results leave in acceptance order with none lost.
- R10: The selector is taken with each accepted sample, so changing it affects where the next accepted sample is written and nothing already stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dly_sel | input | 9 | Echo delay selector, in units of 16 samples |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 10 | Unsigned input sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 10 | Unsigned mixed result |

## Verification
A wrong sample index or write position shows up as a wrong echo value. It does not appear right away: it surfaces only once the echo source is read back, which is 16·S samples later, or a full ring later when the selector is zero. So each delay setting needs a run of at least that many samples. A store that is not cleared shows up only in the earliest results after reset. A pipeline stage that loses its hold under back-pressure corrupts or duplicates a result in the very next cycle that the consumer stalls.

// File: rtl/echo_pkg.sv
package echo_pkg;
  localparam int DEF_ADDR_W = 11;
  localparam int DEF_DATA_W = 10;
  localparam int DEF_SEL_W  = 9;
  localparam int DEF_SHIFT  = 4;
  localparam int DEF_IN_BIAS  = 'h181;
  localparam int DEF_OUT_BIAS = 'h200;

  typedef enum logic {
    RING_SWEEP = 1'b0,
    RING_RUN   = 1'b1
  } ring_state_e;
endpackage

// File: rtl/echo_ring_ctrl.sv
module echo_ring_ctrl #(
  parameter int ADDR_W = echo_pkg::DEF_ADDR_W,
  parameter int SEL_W  = echo_pkg::DEF_SEL_W,
  parameter int SHIFT  = echo_pkg::DEF_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [SEL_W-1:0]  dly_sel,
  output logic              sweeping,
  output logic [ADDR_W-1:0] sweep_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr
);
  import echo_pkg::*;

  localparam int OFF_W = SEL_W + SHIFT;
  localparam logic [ADDR_W-1:0] LAST = '1;

  ring_state_e      state_q;
  logic [OFF_W-1:0] offset;

  assign sweeping = (state_q == RING_SWEEP);
  assign offset   = {dly_sel, {SHIFT{1'b0}}};
  assign wr_addr  = rd_addr + ADDR_W'(offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= RING_SWEEP;
      sweep_addr <= '0;
    end else if (state_q == RING_SWEEP) begin
      sweep_addr <= sweep_addr + 1'b1;
      if (sweep_addr == LAST) state_q <= RING_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_addr <= '0;
    else if (accept) rd_addr <= rd_addr + 1'b1;
  end

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_addr == $past(rd_addr) + 1'b1);

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(rd_addr));

  // R1
  sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sweeping) |-> $past(sweep_addr) == LAST);

  // R1
  no_take_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !accept);
endmodule

// File: rtl/echo_store.sv
module echo_store #(
  parameter int ADDR_W = echo_pkg::DEF_ADDR_W,
  parameter int WORD_W = echo_pkg::DEF_DATA_W - 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // read-first: a same-address write in this cycle is not seen by the read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/echo_mix.sv
module echo_mix #(
  parameter int DATA_W   = echo_pkg::DEF_DATA_W,
  parameter int IN_BIAS  = echo_pkg::DEF_IN_BIAS,
  parameter int OUT_BIAS = echo_pkg::DEF_OUT_BIAS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-2:0] echo_raw,
  output logic              stage_free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              p_valid;
  logic [DATA_W-1:0] x_q;
  logic              move;
  logic signed [DATA_W-1:0] echo_ext;
  logic signed [DATA_W-1:0] echo_half;
  logic [DATA_W-1:0] mixed;

  assign move       = !out_valid || out_ready;
  assign stage_free = !p_valid || move;

  assign echo_ext  = signed'({echo_raw[DATA_W-2], echo_raw});
  assign echo_half = echo_ext >>> 1;
  assign mixed     = x_q - DATA_W'(IN_BIAS) + DATA_W'(echo_half) + DATA_W'(OUT_BIAS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      x_q     <= '0;
    end else if (accept) begin
      p_valid <= 1'b1;
      x_q     <= in_data;
    end else if (move) begin
      p_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (p_valid && move) begin
      out_valid <= 1'b1;
      out_data  <= mixed;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && !move |=> p_valid && $stable(x_q));

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> stage_free);
endmodule

// File: rtl/echo_delay_mixer.sv
module echo_delay_mixer #(
  parameter int ADDR_W   = echo_pkg::DEF_ADDR_W,
  parameter int DATA_W   = echo_pkg::DEF_DATA_W,
  parameter int SEL_W    = echo_pkg::DEF_SEL_W,
  parameter int SHIFT    = echo_pkg::DEF_SHIFT,
  parameter int IN_BIAS  = echo_pkg::DEF_IN_BIAS,
  parameter int OUT_BIAS = echo_pkg::DEF_OUT_BIAS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  dly_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int WORD_W = DATA_W - 1;

  logic              sweeping;
  logic [ADDR_W-1:0] sweep_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic              stage_free;
  logic              accept;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [WORD_W-1:0] mem_wdata;
  logic [WORD_W-1:0] mem_rdata;

  assign in_ready  = !sweeping && stage_free;
  assign accept    = in_valid && in_ready;
  assign mem_we    = sweeping || accept;
  assign mem_waddr = sweeping ? sweep_addr : wr_addr;
  assign mem_wdata = sweeping ? '0 : in_data[WORD_W-1:0];

  echo_ring_ctrl #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SHIFT(SHIFT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .dly_sel(dly_sel),
    .sweeping(sweeping), .sweep_addr(sweep_addr),
    .rd_addr(rd_addr), .wr_addr(wr_addr)
  );

  echo_store #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(accept), .raddr(rd_addr), .rdata(mem_rdata)
  );

  echo_mix #(
    .DATA_W(DATA_W), .IN_BIAS(IN_BIAS), .OUT_BIAS(OUT_BIAS)
  ) u_mix (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_data(in_data),
    .echo_raw(mem_rdata), .stage_free(stage_free),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // R1
  ready_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !in_ready);

  // R1
  quiet_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !out_valid);
endmodule

// File: tb/echo_delay_mixer_bench.sv
module echo_delay_mixer_bench;
  localparam int N = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] dly_sel = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [8:0] model_mem [N];
  int         model_idx = 0;
  logic [9:0] exp_q [$];
  string      tag_q [$];
  string      cur_tag = "R2";

  always #2 clk = ~clk;

  echo_delay_mixer u_echo_delay_mixer (
    .clk(clk), .rst_n(rst_n), .dly_sel(dly_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    out_ready <= stall_en ? lfsr[0] : 1'b1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  function automatic logic [9:0] expect_mix(logic [9:0] din, logic [8:0] word);
    int s, half, r;
    s = (word[8]) ? int'(word) - 512 : int'(word);
    half = (s < 0) ? -((-s + 1) / 2) : s / 2;
    r = int'(din) - 385 + half + 512 + 2048;
    return 10'(r % 1024);
  endfunction

  task automatic send(logic [9:0] d, logic [8:0] sel);
    logic [8:0] word;
    @(negedge clk);
    in_data  = d;
    dly_sel  = sel;
    in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    word = model_mem[model_idx];
    model_mem[(model_idx + int'(sel) * 16) % N] = d[8:0];
    model_idx = (model_idx + 1) % N;
    exp_q.push_back(expect_mix(d, word));
    tag_q.push_back(cur_tag);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    bit         prev_stall = 1'b0;
    logic [9:0] prev_data = '0;
    logic [9:0] e;
    string      t;
    forever begin
      @(negedge clk);
      #1;
      if (!rst_n) continue;
      if (prev_stall) begin
        checks++;
        if (!out_valid || out_data != prev_data) begin
          errors++;
          $display("FAIL R9 hold: actual valid=%0b data=%h expected valid=1 data=%h",
                   out_valid, out_data, prev_data);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 extra result: actual %h expected none", out_data);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_data != e) begin
            errors++;
            $display("FAIL %s mix: actual %h expected %h", t, out_data, e);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  initial begin
    int wait_n;
    for (int i = 0; i < N; i++) model_mem[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual valid=%b ready=%b expected 0 0", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    wait_n = 0;
    while (!in_ready && wait_n < N + 10) begin
      @(negedge clk);
      #1;
      if (!in_ready) wait_n++;
      checks += 0;
    end
    wait_n++;
    checks++;
    if (wait_n < N || wait_n > N + 1) begin
      errors++;
      $display("FAIL R1 sweep length: actual %0d expected %0d", wait_n, N);
    end
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle output: actual %b expected 0", out_valid);
    end

    // R2: first 64 results with selector 4 see a cleared store
    cur_tag = "R2";
    for (int i = 0; i < 64; i++) send(10'(i * 13 + 7), 9'd4);
    // R3: delay of 64 samples
    cur_tag = "R3";
    for (int i = 0; i < 160; i++) send(10'(i * 37 + 100), 9'd4);
    // R4: extreme stored values, positive and negative
    cur_tag = "R4";
    for (int i = 0; i < 128; i++) begin
      logic [9:0] v;
      case (i % 6)
        0: v = 10'h0FF; 1: v = 10'h100; 2: v = 10'h1FF;
        3: v = 10'h001; 4: v = 10'h000; default: v = 10'h181;
      endcase
      send(v, 9'd2);
    end
    // R5: full input range with idle gaps
    cur_tag = "R5";
    for (int i = 0; i < 96; i++) begin
      send(10'(1023 - i * 11), 9'd2);
      if (i % 8 == 0) go_idle();
    end
    // R10: selector changes mid stream
    cur_tag = "R10";
    for (int i = 0; i < 120; i++) send(10'(i * 29 + 3), (i < 60) ? 9'd1 : 9'd3);
    // R6 and R7: selector 0 over more than one ring, crossing the wrap
    for (int i = 0; i < N + 120; i++) begin
      cur_tag = (i < N) ? "R7" : "R6";
      send(10'(i * 7 + 11), 9'd0);
    end
    // R8: bit 9 set on stored inputs
    cur_tag = "R8";
    for (int i = 0; i < 96; i++) send(10'h200 | 10'(i * 5), 9'd1);
    // R9: random back-pressure
    cur_tag = "R9";
    stall_en = 1'b1;
    for (int i = 0; i < 300; i++) send(10'(i * 19 + 50), 9'd3);
    go_idle();
    wait_n = 0;
    while (exp_q.size() != 0 && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    stall_en = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 drain: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule